// File: doc/BRIEF.md
# Multiplexed Address/Data Read Sequencer

This block is a bus master that fetches single bytes from an asynchronous 8-bit external memory. The memory sits on a 16-bit bus that carries first the address and then the data, and an address latch strobe marks the address phase. An internal client raises a request with a 16-bit address. The sequencer places the whole address on the bus and pulses the latch strobe for two clocks. It then releases the low byte lanes and holds an active-low read strobe for a programmed number of clocks. The byte is captured on the clock edge where the read strobe rises, and it comes back to the client with a one-cycle done pulse.

An 8-bit control register sets the timing, with fields at these bit positions:
- `[4:0]` read strobe width in clocks. A value of 0 is treated as 1.
- `[5]` adds one hold clock after the transfer.
- `[6]` adds a seven-clock recovery gap before the next transfer can start.
- `[7]` makes the latch strobe active low. It resets to 0, so the strobe starts out active high.

The register can only be written while the sequencer is idle. Every clock of the sequencer counts as one peripheral clock. The pad-level tristate is split into separate drive values, two output enables (one for each byte lane) and a low-byte input.

Top module: `mux_rd_seq`

## Requirements
- R1: After reset the outputs sit at idle levels: `ale`=0, `rd_n`=1, `wr_n`=1, both output enables 0, `req_ready`=1 and `rsp_valid`=0.
- R2: A request is accepted only while `req_ready` is high, and `req_ready` is high only in idle. A `req_valid` pulse raised during a transfer starts no extra transfer.
- R3: The latch strobe is active for exactly 2 cycles, starting in the cycle after acceptance. During those cycles `ad_out` carries the full address with both enables high. The address stays driven for one more cycle after the strobe ends.
- R4: The low-byte enable `ad_oe_lo` drops at least one cycle before `rd_n` falls. It stays low for as long as `rd_n` is low.
- R5: `rd_n` stays low for N consecutive cycles, where N is the duration field. A field value of 0 gives 1 cycle.
- R6: The byte on `ad_in` in the last low cycle of `rd_n` appears on `rsp_data`. It comes with a single-cycle `rsp_valid` in the cycle right after `rd_n` rises, which is 4+N cycles after acceptance.
- R7: `ad_oe_hi` is high and `ad_out[15:8]` holds the upper address byte in every cycle where `rd_n` is low, and also in the cycle after.
- R8: With the hold bit (bit 5) set, `req_ready` returns one cycle later than without it.
- R9: With the flash bit (bit 6) set, `req_ready` returns seven cycles later. In total, idle is reached 5+N+hold+7·flash cycles after acceptance.
- R10: Control bit 7 inverts the latch strobe polarity, and this applies both in idle and when active.
- R11: A control write during a transfer is ignored. The next transfer uses the earlier settings.
- R12: `wr_n` stays high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control value: [4:0] width, [5] hold, [6] flash, [7] strobe active low |
| req_valid | input | 1 | Read request |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_addr | input | 16 | Byte address to read |
| rsp_valid | output | 1 | One-cycle done pulse |
| rsp_data | output | 8 | Captured byte |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, always inactive |
| ad_out | output | 16 | Value driven onto the address/data bus |
| ad_oe_hi | output | 1 | Drive enable for bus bits 15..8 |
| ad_oe_lo | output | 1 | Drive enable for bus bits 7..0 |
| ad_in | input | 8 | Low byte sampled from the bus |

## Verification
Every result has a fixed cycle offset, counted from acceptance as cycle 0:
- The latch strobe is active in cycles 0–1.
- The address is still driven in cycle 2.
- The low lanes are released in cycle 3.
- `rd_n` is low in cycles 4 to 3+N.
- The done pulse comes in cycle 4+N.
- `req_ready` returns in cycle 5+N+hold+7·flash.

The bench drives inputs on falling edges and samples once per falling edge, indexed by cycle. It compares the cycle where each event was seen with these offsets, rather than waiting on the event itself. The memory model returns a byte derived from the address seen on the bus, so a wrong address or a wrong capture edge changes the returned data.

// File: rtl/mrs_pkg.sv
// Package: shared widths, sequencer state encoding and control register layout.
// Assumes one sequencer clock equals one peripheral clock.
package mrs_pkg;
    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 8;
    localparam int DUR_W     = 5;
    localparam int ALE_CYC   = 2;
    localparam int FLASH_CYC = 7;
    localparam int CNT_W     = (DUR_W > $clog2(FLASH_CYC + 1)) ? DUR_W : $clog2(FLASH_CYC + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALE,
        ST_AHOLD,
        ST_TURN,
        ST_READ,
        ST_POST,
        ST_HOLD,
        ST_RECOV
    } seq_state_t;

    // Bit 7 strobe polarity, bit 6 flash recovery, bit 5 hold, bits 4..0 width.
    typedef struct packed {
        logic             ale_low;
        logic             flash;
        logic             hold;
        logic [DUR_W-1:0] dur;
    } seq_cfg_t;
endpackage

// File: rtl/mrs_ctl_reg.sv
// Control register: holds the timing setup. Takes writes only while the
// sequencer is idle, so the settings stay fixed for a whole transfer.
// Assumes busy is high for every non-idle state.
module mrs_ctl_reg
    import mrs_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     we,
    input  logic [$bits(seq_cfg_t)-1:0] wdata,
    input  logic     busy,
    output seq_cfg_t cfg
);
    // Register update: reset to zero (active-high strobe, width 1), idle writes only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (we && !busy) begin
            cfg <= seq_cfg_t'(wdata);
        end
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (we && busy) |=> (cfg == $past(cfg))); // R11
endmodule

// File: rtl/mrs_fsm.sv
// Sequencer control: walks through latch, address hold, turnaround, read,
// post, optional hold and optional recovery, timing each with one counter.
// Assumes the timing inputs do not change while busy.
module mrs_fsm
    import mrs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [DUR_W-1:0] dur,
    input  logic             hold,
    input  logic             flash,
    output seq_state_t       state,
    output logic             req_ready,
    output logic             read_last
);
    logic [CNT_W-1:0] cnt;

    // Handshake and last-read-cycle flag, decoded from state and counter.
    always_comb begin
        req_ready = (state == ST_IDLE);
        read_last = (state == ST_READ) && (cnt == '0);
    end

    // State and counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    state <= ST_ALE;
                    cnt   <= CNT_W'(ALE_CYC - 1);
                end
                ST_ALE: if (cnt == '0) state <= ST_AHOLD;
                        else cnt <= cnt - 1'b1;
                ST_AHOLD: state <= ST_TURN;
                ST_TURN: begin
                    state <= ST_READ;
                    cnt   <= (dur == '0) ? '0 : CNT_W'(dur - 1'b1);
                end
                ST_READ: if (cnt == '0) state <= ST_POST;
                         else cnt <= cnt - 1'b1;
                ST_POST: if (hold) begin
                    state <= ST_HOLD;
                end else if (flash) begin
                    state <= ST_RECOV;
                    cnt   <= CNT_W'(FLASH_CYC - 1);
                end else begin
                    state <= ST_IDLE;
                end
                ST_HOLD: if (flash) begin
                    state <= ST_RECOV;
                    cnt   <= CNT_W'(FLASH_CYC - 1);
                end else begin
                    state <= ST_IDLE;
                end
                ST_RECOV: if (cnt == '0) state <= ST_IDLE;
                          else cnt <= cnt - 1'b1;
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_ACCEPT_STARTS_ALE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (state == ST_ALE)); // R3
    AST_ALE_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_ALE && state == ST_AHOLD) |-> ($past(state, 2) == ST_ALE)); // R3
    AST_READ_FOLLOWS_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TURN) |=> (state == ST_READ)); // R4
endmodule

// File: rtl/mrs_pads.sv
// Pad-side outputs: latches the address on acceptance, decodes strobes and
// lane enables from the state, and captures the byte on the last read cycle
// (the edge where the read strobe rises). Assumes state comes from mrs_fsm.
module mrs_pads
    import mrs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  seq_state_t        state,
    input  logic              read_last,
    input  logic              ale_low,
    input  logic [DATA_W-1:0] ad_in,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic [ADDR_W-1:0] ad_out,
    output logic              ad_oe_hi,
    output logic              ad_oe_lo,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    logic [ADDR_W-1:0] addr_q;

    // Address latch taken at request acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) addr_q <= '0;
        else if (accept) addr_q <= req_addr;
    end

    // Read byte capture at the rising edge of the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) rsp_data <= '0;
        else if (read_last) rsp_data <= ad_in;
    end

    // Strobe and lane-enable decode.
    always_comb begin
        ale       = (state == ST_ALE) ^ ale_low;
        rd_n      = (state != ST_READ);
        wr_n      = 1'b1;
        ad_out    = addr_q;
        ad_oe_lo  = (state == ST_ALE) || (state == ST_AHOLD);
        ad_oe_hi  = (state == ST_ALE) || (state == ST_AHOLD) || (state == ST_TURN)
                 || (state == ST_READ) || (state == ST_POST);
        rsp_valid = (state == ST_POST);
    end

    AST_LO_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe_lo); // R4
    AST_HI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_n) |-> ad_oe_hi); // R7
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_oe_lo && $past(ad_oe_lo)) |-> $stable(ad_out)); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R6
endmodule

// File: rtl/mux_rd_seq.sv
// Top: byte read sequencer for a multiplexed 16-bit address/data bus.
// Joins the control register, the sequencer control and the pad decode.
// Assumes the bus tristate is built outside from ad_out and the two enables.
module mux_rd_seq
    import mrs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic [ADDR_W-1:0] ad_out,
    output logic              ad_oe_hi,
    output logic              ad_oe_lo,
    input  logic [DATA_W-1:0] ad_in
);
    seq_cfg_t   cfg;
    seq_state_t state;
    logic       read_last;

    mrs_ctl_reg u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .busy  (!req_ready),
        .cfg   (cfg)
    );

    mrs_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .dur       (cfg.dur),
        .hold      (cfg.hold),
        .flash     (cfg.flash),
        .state     (state),
        .req_ready (req_ready),
        .read_last (read_last)
    );

    mrs_pads u_pads (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (req_valid && req_ready),
        .req_addr  (req_addr),
        .state     (state),
        .read_last (read_last),
        .ale_low   (cfg.ale_low),
        .ad_in     (ad_in),
        .ale       (ale),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .ad_out    (ad_out),
        .ad_oe_hi  (ad_oe_hi),
        .ad_oe_lo  (ad_oe_lo),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    AST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> wr_n); // R12
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R2
endmodule

// File: tb/tb_mux_rd_seq.sv
// Directed bench: one task per scenario, each checking its own cycle-indexed results.
module tb_mux_rd_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = 8'h00;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_addr = 16'h0000;
    logic        rsp_valid;
    logic [7:0]  rsp_data;
    logic        ale, rd_n, wr_n, ad_oe_hi, ad_oe_lo;
    logic [15:0] ad_out;
    logic [7:0]  ad_in;
    logic [7:0]  lo_seen = 8'h00;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    // Memory model: drives data only while the read strobe is low.
    assign ad_in = !rd_n ? mem_byte({ad_out[15:8], lo_seen}) : 8'h00;

    mux_rd_seq dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .ale(ale), .rd_n(rd_n),
        .wr_n(wr_n), .ad_out(ad_out), .ad_oe_hi(ad_oe_hi), .ad_oe_lo(ad_oe_lo),
        .ad_in(ad_in)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic set_cfg(input logic [4:0] dur, input bit hold, input bit flash, input bit alow);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = {alow, flash, hold, dur};
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic test_reset();
        chk(ale == 1'b0, "R1 ale", ale, 0);
        chk(rd_n == 1'b1 && wr_n == 1'b1, "R1 strobes", {rd_n, wr_n}, 3);
        chk(!ad_oe_hi && !ad_oe_lo, "R1 enables", {ad_oe_hi, ad_oe_lo}, 0);
        chk(req_ready && !rsp_valid, "R1 handshake", {req_ready, rsp_valid}, 2);
    endtask

    // One full read with cycle-indexed checks; cycle 0 is the first after acceptance.
    task automatic run_read(input logic [15:0] addr, input int dur, input bit hold,
                            input bit flash, input bit alow, input bit poke_req,
                            input bit poke_cfg);
        int d, ale_cnt, ale_first, rd_cnt, rd_first, rsp_cnt, rsp_k, done_k;
        bit addr_bad, oe_bad, post_bad, wr_bad, k2_ok, k3_ok;
        logic [7:0] rsp_d;
        d = (dur == 0) ? 1 : dur;
        ale_cnt = 0; ale_first = -1; rd_cnt = 0; rd_first = -1;
        rsp_cnt = 0; rsp_k = -1; done_k = -1; rsp_d = 8'h00;
        addr_bad = 0; oe_bad = 0; post_bad = 0; wr_bad = 0; k2_ok = 0; k3_ok = 0;
        chk(ale == alow, "R10 idle level", ale, alow);
        @(negedge clk);
        req_addr = addr;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 80; k++) begin
            if (k == 0) lo_seen = ad_out[7:0];
            if (ale ^ alow) begin
                ale_cnt++;
                if (ale_first < 0) ale_first = k;
                if (!(ad_oe_hi && ad_oe_lo && ad_out == addr)) addr_bad = 1;
            end
            if (k == 2) k2_ok = ad_oe_hi && ad_oe_lo && (ad_out == addr) && !(ale ^ alow);
            if (k == 3) k3_ok = ad_oe_hi && !ad_oe_lo && rd_n;
            if (!rd_n) begin
                rd_cnt++;
                if (rd_first < 0) rd_first = k;
                if (ad_oe_lo || !ad_oe_hi || ad_out[15:8] != addr[15:8]) oe_bad = 1;
            end
            if (rsp_valid) begin
                rsp_cnt++;
                rsp_k = k;
                rsp_d = rsp_data;
                if (!ad_oe_hi || ad_out[15:8] != addr[15:8]) post_bad = 1;
            end
            if (!wr_n) wr_bad = 1;
            if (req_ready) begin
                done_k = k;
                break;
            end
            @(negedge clk);
            if (poke_req) req_valid = (k == 2);
            if (poke_cfg) begin
                cfg_we = (k == 2);
                cfg_wdata = 8'h1F;
            end
        end
        req_valid = 1'b0;
        cfg_we = 1'b0;
        chk(ale_cnt == 2 && ale_first == 0, "R3 strobe width/start", ale_cnt, 2);
        chk(!addr_bad, "R3 address during strobe", addr_bad, 0);
        chk(k2_ok, "R3 address hold cycle", k2_ok, 1);
        chk(k3_ok, "R4 low lanes released before read", k3_ok, 1);
        chk(rd_cnt == d && rd_first == 4, "R5 read width", rd_cnt, d);
        chk(!oe_bad, "R4 R7 lanes during read", oe_bad, 0);
        chk(rsp_cnt == 1 && rsp_k == 4 + d, "R6 done cycle", rsp_k, 4 + d);
        chk(rsp_d == mem_byte(addr), "R6 data", rsp_d, mem_byte(addr));
        chk(!post_bad, "R7 upper byte after read", post_bad, 0);
        chk(done_k == 5 + d + int'(hold) + 7 * int'(flash), "R8 R9 ready return",
            done_k, 5 + d + int'(hold) + 7 * int'(flash));
        chk(!wr_bad, "R12 write strobe", wr_bad, 0);
        if (poke_req) begin
            for (int j = 0; j < 3; j++) begin
                @(negedge clk);
                chk(!(ale ^ alow) && rd_n && req_ready, "R2 busy request dropped", ale, alow);
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        run_read(16'h1234, 0, 0, 0, 0, 0, 0);          // R5 zero width -> 1
        set_cfg(5'd4, 0, 0, 0);
        run_read(16'hA5C3, 4, 0, 0, 0, 0, 0);          // R6 basic
        set_cfg(5'd31, 0, 0, 0);
        run_read(16'hFF00, 31, 0, 0, 0, 0, 0);         // R5 max width
        set_cfg(5'd2, 1, 0, 0);
        run_read(16'h0F0F, 2, 1, 0, 0, 0, 0);          // R8 hold
        set_cfg(5'd3, 0, 1, 0);
        run_read(16'h8001, 3, 0, 1, 0, 0, 0);          // R9 flash
        set_cfg(5'd1, 1, 1, 0);
        run_read(16'h7E81, 1, 1, 1, 0, 0, 0);          // R8 R9 both
        set_cfg(5'd2, 0, 0, 1);
        run_read(16'h3C96, 2, 0, 0, 1, 0, 0);          // R10 active-low strobe
        set_cfg(5'd3, 0, 0, 0);
        run_read(16'h4242, 3, 0, 0, 0, 1, 0);          // R2 busy request
        run_read(16'h9ABC, 3, 0, 0, 0, 0, 1);          // R11 busy cfg write
        run_read(16'hDEAD, 3, 0, 0, 0, 0, 0);          // R11 old setting kept
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule